// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits between a CPU register port and a one-time-programmable fuse array. Software loads a command code, a word address and a data word into registers, then writes 1 to the start bit. The controller runs the command, marks it done in a status register and, for a program command, reports whether the fuses were burned. Software writes the start bit back to 0 once it has seen done. That write clears the completion flags and makes the controller ready for the next command.

The fuse array is a behavioural store of `NUM_WORDS` words whose bits can only change from 0 to 1. Burning is disabled until software sends the unlock key as a series of program-enable commands. A program command takes longer the more 1 bits its data word carries. Error correction is turned on and off by an ECC command that must name a fixed address and carry a fixed pattern. The CPU port is a simple write strobe with an address and a data word. Read data is a combinational function of the address.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset every register reads 0. The register offsets are mode 0x00, command 0x04, start 0x08, status 0x0C, address 0x28, write data 0x2C and read data 0x30. Status bits are: 0 busy, 1 done, 2 program-ok, 3 ECC on, 4 unlocked.
- R2: The command register keeps only bits 5:0 and the address register keeps only bits 15:0. Higher bits that are written are dropped on readback and in the address the command uses.
- R3: While mode bit 0 is 0, every command finishes one cycle after launch with done set and program-ok clear. It has no other effect: read data, fuse contents, the unlock state and the ECC state stay unchanged.
- R4: Writing 1 to start bit 0 while idle launches the command held in the registers. Busy reads 1 in the launch cycle and stays 1 until done rises. Done rises a fixed number of cycles after the launch edge, and busy falls in the same cycle. Command codes other than 0x00, 0x02, 0x03, 0x08 and 0x10 finish in one cycle with no effect.
- R5: Read (code 0x00) finishes `READ_LAT` cycles after launch and places the addressed word in the read-data register. A word that was never burned, and any address at or above `NUM_WORDS`, reads as 0.
- R6: A program (code 0x08) that is allowed finishes `PROG_BASE + PROG_PER_BIT * n` cycles after launch, where n is the number of 1 bits in the data word.
- R7: An allowed program ORs the data into the stored word and sets program-ok. A stored 1 never returns to 0.
- R8: Unlocking takes program-enable commands (code 0x02) whose data bits 3:0 carry 0xF, 0x4, 0x8 and 0xD in that order. A wrong nibble restarts the key, and a wrong nibble of 0xF counts as the first step of a new attempt. Each program-enable finishes in one cycle.
- R9: Program-disable (code 0x03) clears the unlocked state and the key progress. A program issued while locked finishes in one cycle with program-ok clear and leaves the fuses unchanged.
- R10: An ECC command (code 0x10) to address 0x1A with data 0x00EC0000 turns ECC off. The same command with data 0xFF13FFFF turns ECC on. Any other address or data leaves the ECC state unchanged. ECC is off after reset.
- R11: Writing 0 to start bit 0 after done clears done and program-ok, leaves ECC and unlocked as they were, and returns the controller to idle.
- R12: A program to an address at or above `NUM_WORDS` finishes in one cycle with program-ok clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrite | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte offset |
| busWdata | input | DATA_W | Register write data |
| busRdata | output | DATA_W | Read data for the register at busAddr (combinational) |

## Verification
The bench builds the block with `NUM_WORDS` = 64, `READ_LAT` = 3, `PROG_BASE` = 6 and `PROG_PER_BIT` = 2. With these values the all-ones program takes 70 cycles, so the longest latency is measured exactly within a short run. The small array also puts the last valid word (63) and the first address past the end (64) within reach. The address 0x10003 folds to word 3, which shows that the upper address bits are dropped. A scoreboard compares every completion cycle, status word and read value against a reference model built from the requirements.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int CMD_W = 6;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] OFF_MODE   = 8'h00;
  localparam logic [REG_AW-1:0] OFF_CMD    = 8'h04;
  localparam logic [REG_AW-1:0] OFF_START  = 8'h08;
  localparam logic [REG_AW-1:0] OFF_STATUS = 8'h0C;
  localparam logic [REG_AW-1:0] OFF_ADDR   = 8'h28;
  localparam logic [REG_AW-1:0] OFF_WDATA  = 8'h2C;
  localparam logic [REG_AW-1:0] OFF_RDATA  = 8'h30;

  localparam logic [CMD_W-1:0] OP_READ     = 6'h00;
  localparam logic [CMD_W-1:0] OP_ARM      = 6'h02;
  localparam logic [CMD_W-1:0] OP_DISARM   = 6'h03;
  localparam logic [CMD_W-1:0] OP_BURN     = 6'h08;
  localparam logic [CMD_W-1:0] OP_ECC      = 6'h10;

  localparam int         ECC_CFG_ADDR = 'h1A;
  localparam logic [31:0] ECC_OFF_WORD = 32'h00EC0000;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } ctlState_t;

  typedef struct packed {
    logic capture;
    logic finish;
    logic clearStatus;
  } ctlStrobe_t;

  function automatic logic [3:0] keyNibble(input logic [1:0] step);
    case (step)
      2'd0:    return 4'hF;
      2'd1:    return 4'h4;
      2'd2:    return 4'h8;
      default: return 4'hD;
    endcase
  endfunction

endpackage

// File: rtl/otp_control.sv
module otp_control
  import otp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startSet,
  input  logic             startClr,
  input  logic [CNT_W-1:0] latency,
  output ctlStrobe_t       strobes,
  output logic             busy
);

  ctlState_t        state;
  logic [CNT_W-1:0] remain;

  always_comb begin
    strobes = '0;
    case (state)
      ST_IDLE: strobes.capture     = startSet;
      ST_RUN:  strobes.finish      = (remain == CNT_W'(1));
      ST_HOLD: strobes.clearStatus = startClr;
      default: strobes = '0;
    endcase
  end

  assign busy = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remain <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startSet) begin
            state  <= ST_RUN;
            remain <= (latency == '0) ? CNT_W'(1) : latency;
          end
        end
        ST_RUN: begin
          if (remain == CNT_W'(1)) state <= ST_HOLD;
          else                     remain <= remain - CNT_W'(1);
        end
        ST_HOLD: begin
          if (startClr) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/otp_datapath.sv
module otp_datapath
  import otp_pkg::*;
#(
  parameter int NUM_WORDS    = 2048,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 16,
  parameter int READ_LAT     = 4,
  parameter int PROG_BASE    = 40,
  parameter int PROG_PER_BIT = 12,
  parameter int CNT_W        = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [REG_AW-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  ctlStrobe_t        strobes,
  input  logic              busy,
  output logic              startSet,
  output logic              startClr,
  output logic [CNT_W-1:0]  latency,
  output logic [4:0]        statusVec
);

  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [DATA_W-1:0] ECC_OFF = DATA_W'(ECC_OFF_WORD);

  logic              modeOn, startBit, done, progOk, eccOn, unlocked, capMode;
  logic [1:0]        keyStep;
  logic [CMD_W-1:0]  cmdReg, capCmd;
  logic [ADDR_W-1:0] addrReg, capAddr;
  logic [DATA_W-1:0] wdataReg, capData, rdataReg;
  logic [NUM_WORDS-1:0] burned;
  logic [DATA_W-1:0] fuseMem [NUM_WORDS];

  logic              liveInRange, capInRange, burnGo;
  logic [IDX_W-1:0]  capIdx;
  logic [DATA_W-1:0] storedWord;

  function automatic logic [CNT_W-1:0] countSet(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < DATA_W; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  assign startSet    = busWrite && (busAddr == OFF_START) && busWdata[0];
  assign startClr    = busWrite && (busAddr == OFF_START) && !busWdata[0];
  assign liveInRange = int'(addrReg) < NUM_WORDS;
  assign capInRange  = int'(capAddr) < NUM_WORDS;
  assign capIdx      = capAddr[IDX_W-1:0];
  assign storedWord  = (capInRange && burned[capIdx]) ? fuseMem[capIdx] : '0;
  assign burnGo      = capMode && (capCmd == OP_BURN) && unlocked && capInRange;
  assign statusVec   = {unlocked, eccOn, progOk, done, busy};

  // Cycles from launch to done, chosen from the live register contents.
  always_comb begin
    latency = CNT_W'(1);
    if (modeOn) begin
      if (cmdReg == OP_READ)
        latency = CNT_W'(READ_LAT);
      else if (cmdReg == OP_BURN && unlocked && liveInRange)
        latency = CNT_W'(PROG_BASE) + CNT_W'(PROG_PER_BIT) * countSet(wdataReg);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeOn   <= 1'b0;
      startBit <= 1'b0;
      cmdReg   <= '0;
      addrReg  <= '0;
      wdataReg <= '0;
      capCmd   <= '0;
      capAddr  <= '0;
      capData  <= '0;
      capMode  <= 1'b0;
      rdataReg <= '0;
      done     <= 1'b0;
      progOk   <= 1'b0;
      eccOn    <= 1'b0;
      unlocked <= 1'b0;
      keyStep  <= 2'd0;
      burned   <= '0;
    end else begin
      if (busWrite) begin
        case (busAddr)
          OFF_MODE:  modeOn   <= busWdata[0];
          OFF_CMD:   cmdReg   <= busWdata[CMD_W-1:0];
          OFF_START: startBit <= busWdata[0];
          OFF_ADDR:  addrReg  <= busWdata[ADDR_W-1:0];
          OFF_WDATA: wdataReg <= busWdata;
          default: ;
        endcase
      end
      if (strobes.capture) begin
        capCmd  <= cmdReg;
        capAddr <= addrReg;
        capData <= wdataReg;
        capMode <= modeOn;
      end
      if (strobes.clearStatus) begin
        done   <= 1'b0;
        progOk <= 1'b0;
      end
      if (strobes.finish) begin
        done <= 1'b1;
        if (capMode) begin
          case (capCmd)
            OP_READ: rdataReg <= storedWord;
            OP_ARM: begin
              if (capData[3:0] == keyNibble(keyStep)) begin
                if (keyStep == 2'd3) begin
                  unlocked <= 1'b1;
                  keyStep  <= 2'd0;
                end else begin
                  keyStep <= keyStep + 2'd1;
                end
              end else begin
                keyStep <= (capData[3:0] == 4'hF) ? 2'd1 : 2'd0;
              end
            end
            OP_DISARM: begin
              unlocked <= 1'b0;
              keyStep  <= 2'd0;
            end
            OP_BURN: begin
              progOk <= burnGo;
              if (burnGo) burned[capIdx] <= 1'b1;
            end
            OP_ECC: begin
              if (int'(capAddr) == ECC_CFG_ADDR) begin
                if (capData == ECC_OFF)       eccOn <= 1'b0;
                else if (capData == ~ECC_OFF) eccOn <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // Fuse storage: no reset, validity tracked by the burned vector.
  always_ff @(posedge clk) begin
    if (strobes.finish && burnGo) fuseMem[capIdx] <= storedWord | capData;
  end

  always_comb begin
    case (busAddr)
      OFF_MODE:   busRdata = DATA_W'(modeOn);
      OFF_CMD:    busRdata = DATA_W'(cmdReg);
      OFF_START:  busRdata = DATA_W'(startBit);
      OFF_STATUS: busRdata = DATA_W'(statusVec);
      OFF_ADDR:   busRdata = DATA_W'(addrReg);
      OFF_WDATA:  busRdata = wdataReg;
      OFF_RDATA:  busRdata = rdataReg;
      default:    busRdata = '0;
    endcase
  end

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int NUM_WORDS    = 2048,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 16,
  parameter int READ_LAT     = 4,
  parameter int PROG_BASE    = 40,
  parameter int PROG_PER_BIT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [7:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);

  localparam int CNT_W = $clog2(PROG_BASE + PROG_PER_BIT * DATA_W + READ_LAT + 2);

  ctlStrobe_t       ctlStrobes;
  logic             busy, startSet, startClr;
  logic [CNT_W-1:0] latency;
  logic [4:0]       statusVec;

  otp_control #(.CNT_W(CNT_W)) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .startSet (startSet),
    .startClr (startClr),
    .latency  (latency),
    .strobes  (ctlStrobes),
    .busy     (busy)
  );

  otp_datapath #(
    .NUM_WORDS    (NUM_WORDS),
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .READ_LAT     (READ_LAT),
    .PROG_BASE    (PROG_BASE),
    .PROG_PER_BIT (PROG_PER_BIT),
    .CNT_W        (CNT_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .strobes   (ctlStrobes),
    .busy      (busy),
    .startSet  (startSet),
    .startClr  (startClr),
    .latency   (latency),
    .statusVec (statusVec)
  );

endmodule

// File: rtl/otp_fuse_ctrl_checker.sv
module otp_fuse_ctrl_checker (
  input logic       clk,
  input logic       rstN,
  input logic       startClr,
  input logic [4:0] statusVec
);

  // statusVec: 0 busy, 1 done, 2 program-ok, 3 ecc on, 4 unlocked
  a_r4_busy_excludes_done: assert property (@(posedge clk) disable iff (!rstN)
    statusVec[0] |-> !statusVec[1]);

  a_r4_done_follows_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[1]) |-> $past(statusVec[0]));

  a_r7_ok_implies_done: assert property (@(posedge clk) disable iff (!rstN)
    statusVec[2] |-> statusVec[1]);

  a_r9_ok_needs_unlock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[2]) |-> statusVec[4]);

  a_r8_unlock_only_by_command: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[4]) |-> $past(statusVec[0]));

  a_r11_clear_drops_done: assert property (@(posedge clk) disable iff (!rstN)
    (startClr && statusVec[1]) |=> (!statusVec[1] && !statusVec[2]));

endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_checker u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .startClr  (startClr),
  .statusVec (statusVec)
);

// File: tb/test_otp_fuse_ctrl.sv
module test_otp_fuse_ctrl;
  import otp_pkg::*;

  localparam int WORDS = 64;
  localparam int RL    = 3;
  localparam int PB    = 6;
  localparam int PPB   = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  otp_fuse_ctrl #(
    .NUM_WORDS(WORDS), .DATA_W(32), .ADDR_W(16),
    .READ_LAT(RL), .PROG_BASE(PB), .PROG_PER_BIT(PPB)
  ) i_otp_fuse_ctrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    string       tag;
    int          lat;
    int          launch;
    logic [31:0] stat;
    logic [31:0] rd;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [31:0] mMem [WORDS];
  bit          mMode = 0, mUnl = 0, mEcc = 0;
  int          mStep = 0;
  logic [31:0] mRd = '0;
  logic [3:0]  keySeq [4] = '{4'hF, 4'h4, 4'h8, 4'hD};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdata;
  endtask

  // driver: program registers, predict, launch, push expectation, release
  task automatic doCmd(input string tag, input logic [31:0] c,
                       input logic [31:0] a, input logic [31:0] d);
    int lat; bit ok; logic [31:0] cm, am, v;
    expItem_t it;
    lat = 1; ok = 0;
    cm = c & 32'h3F; am = a & 32'hFFFF;
    busWr(OFF_CMD, c); busWr(OFF_ADDR, a); busWr(OFF_WDATA, d);
    if (mMode) begin
      case (cm)
        32'h00: begin lat = RL; mRd = (am < WORDS) ? mMem[am] : 32'h0; end
        32'h02: begin
          if (d[3:0] == keySeq[mStep]) begin
            if (mStep == 3) begin mUnl = 1; mStep = 0; end
            else mStep++;
          end else mStep = (d[3:0] == 4'hF) ? 1 : 0;
        end
        32'h03: begin mUnl = 0; mStep = 0; end
        32'h08: if (mUnl && am < WORDS) begin
          lat = PB + PPB * $countones(d); mMem[am] = mMem[am] | d; ok = 1;
        end
        32'h10: if (am == 32'h1A) begin
          if (d == 32'h00EC0000) mEcc = 0;
          else if (d == 32'hFF13FFFF) mEcc = 1;
        end
        default: ;
      endcase
    end
    busWr(OFF_START, 32'h1);
    it.launch = cyc;
    busAddr = OFF_STATUS;
    #1 check({tag, " R4 busy at launch"}, {30'b0, busRdata[1:0]}, 32'h1);
    it.tag = tag; it.lat = lat; it.rd = mRd;
    it.stat = {27'b0, mUnl, mEcc, ok, 1'b1, 1'b0};
    expQ.push_back(it);
    while (expQ.size() != 0) @(negedge clk);
    busWr(OFF_START, 32'h0);
    busRd(OFF_STATUS, v);
    check({tag, " R11 status after start cleared"}, v, {27'b0, mUnl, mEcc, 3'b000});
  endtask

  // monitor: waits for done and compares against the oldest expectation
  initial begin
    forever begin
      @(negedge clk); #2;
      if (expQ.size() > 0 && busRdata[1]) begin
        check({expQ[0].tag, " latency"}, 32'(cyc - expQ[0].launch), 32'(expQ[0].lat));
        check({expQ[0].tag, " status at done"}, busRdata, expQ[0].stat);
        busAddr = OFF_RDATA;
        #1 check({expQ[0].tag, " read data"}, busRdata, expQ[0].rd);
        busAddr = OFF_STATUS;
        void'(expQ.pop_front());
      end
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog actual=hung expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < WORDS; i++) mMem[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset values
    busRd(OFF_STATUS, v); check("R1 status", v, 32'h0);
    busRd(OFF_MODE, v);   check("R1 mode", v, 32'h0);
    busRd(OFF_CMD, v);    check("R1 command", v, 32'h0);
    busRd(OFF_ADDR, v);   check("R1 address", v, 32'h0);
    busRd(OFF_RDATA, v);  check("R1 read data", v, 32'h0);

    // R2 field masking
    busWr(OFF_CMD, 32'hFFC5);    busRd(OFF_CMD, v);  check("R2 command mask", v, 32'h05);
    busWr(OFF_ADDR, 32'hABCDE);  busRd(OFF_ADDR, v); check("R2 address mask", v, 32'hBCDE);

    // R3 mode off
    doCmd("R3 burn with mode off", 32'h08, 32'd3, 32'hFF);
    doCmd("R3 read with mode off", 32'h00, 32'd3, 32'h0);
    busWr(OFF_MODE, 32'h1); mMode = 1;
    busRd(OFF_MODE, v); check("R3 mode readback", v, 32'h1);

    doCmd("R5 read blank word", 32'h00, 32'd5, 32'h0);
    doCmd("R9 burn while locked", 32'h08, 32'd3, 32'hF0);
    doCmd("R5 read after locked burn", 32'h00, 32'd3, 32'h0);

    // R8 key with wrong nibbles and a 0xF restart
    doCmd("R8 key F", 32'h02, 32'd0, 32'hF);
    doCmd("R8 key 4", 32'h02, 32'd0, 32'h4);
    doCmd("R8 key wrong 7", 32'h02, 32'd0, 32'h7);
    doCmd("R8 key F", 32'h02, 32'd0, 32'hF);
    doCmd("R8 key F restart", 32'h02, 32'd0, 32'hF);
    doCmd("R8 key 4", 32'h02, 32'd0, 32'h4);
    doCmd("R8 key 8", 32'h02, 32'd0, 32'h8);
    doCmd("R8 key D unlock", 32'h02, 32'd0, 32'hD);

    // R6 / R7 burning
    doCmd("R6 burn F0", 32'h08, 32'd3, 32'hF0);
    doCmd("R7 read back", 32'h00, 32'd3, 32'h0);
    doCmd("R7 burn OR", 32'h08, 32'd3, 32'h0F0F);
    doCmd("R6 burn zero data", 32'h08, 32'd3, 32'h0);
    doCmd("R7 bits stay set", 32'h00, 32'd3, 32'h0);
    doCmd("R6 burn all ones last word", 32'h08, 32'd63, 32'hFFFFFFFF);
    doCmd("R5 read last word", 32'h00, 32'd63, 32'h0);
    doCmd("R12 burn past end", 32'h08, 32'd64, 32'h1);
    doCmd("R5 read past end", 32'h00, 32'd64, 32'h0);
    doCmd("R2 folded address read", 32'h00, 32'h10003, 32'h0);

    // R10 ECC switch
    doCmd("R10 ecc on", 32'h10, 32'h1A, 32'hFF13FFFF);
    doCmd("R10 ecc wrong address", 32'h10, 32'h1B, 32'h00EC0000);
    doCmd("R10 ecc wrong data", 32'h10, 32'h1A, 32'h12345678);
    doCmd("R10 ecc off", 32'h10, 32'h1A, 32'h00EC0000);

    doCmd("R4 unknown code", 32'h3F, 32'd0, 32'h0);

    // R9 relock
    doCmd("R9 disarm", 32'h03, 32'd0, 32'h0);
    doCmd("R9 burn after disarm", 32'h08, 32'd4, 32'h1);
    doCmd("R9 read untouched", 32'h00, 32'd4, 32'h0);

    // R3 mode off again does not disturb state
    busWr(OFF_MODE, 32'h0); mMode = 0;
    doCmd("R3 read with mode off later", 32'h00, 32'd63, 32'h0);

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule